// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block is the integer multiply unit of a 32-bit RISC core. A one-cycle start strobe captures two operands and a signed/unsigned select. The unit then works through the multiplier two bits per clock. In each step a recoder looks at the two lowest bits of the low result register and at one saved bit. The recoded digit tells a shared adder/subtractor, two bits wider than the operands, whether to add or subtract zero, one or two times the multiplicand. The 64-bit product ends up split across a HI register (upper half) and a LO register (lower half).

The core reads HI and LO through dedicated ports. It can also load either register directly through two write enables that share one data bus. Signed and unsigned operations use the same datapath. The unsigned case differs only in how the multiplicand is extended and in one correction that is folded into the final step.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0 and HI and LO read as 0.
- R2: With the signed select at 0, HI:LO holds the 2*XLEN-bit unsigned product of the two operands when done is high.
- R3: With the signed select at 1, HI:LO holds the 2*XLEN-bit two's-complement product of the two operands when done is high.
- R4: A start accepted while idle raises busy one cycle later. Busy stays high for exactly XLEN/2 cycles. In the cycle busy falls, done is high for one cycle.
- R5: A start strobe seen while busy is ignored: the running product is unaffected and no second operation follows.
- R6: While idle and with no start, the HI write enable loads the data bus into HI and the LO write enable loads it into LO. The other register keeps its value.
- R7: HI and LO write enables asserted while busy have no effect on the product.
- R8: When start and a write enable arrive in the same idle cycle, the start wins and the write is dropped.
- R9: The step digit is picked from the triple {LO[1], LO[0], saved bit}: 000 and 111 give 0, 001 and 010 give +1x, 011 gives +2x, 100 gives -2x, and 101 and 110 give -1x. The saved bit starts at 0 and takes LO[1] on each step.
- R10: The multiplicand is zero-extended for unsigned operations and sign-extended for signed operations. Operands with their top bit set therefore give different products in the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a multiply |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| op_a_i | input | XLEN | Multiplicand |
| op_b_i | input | XLEN | Multiplier |
| hi_we_i | input | 1 | Direct load of HI from wdata_i |
| lo_we_i | input | 1 | Direct load of LO from wdata_i |
| wdata_i | input | XLEN | Data for direct HI/LO loads |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | XLEN | HI register (upper product half) |
| lo_o | output | XLEN | LO register (lower product half) |

## Verification
The product path is checked exhaustively on a 6-bit instance. Every multiplicand is paired with every multiplier, once in each signedness mode. This reaches every recoded digit sequence and separates the zero-extended multiplicand from the sign-extended one, as well as the corrected unsigned top triple from the signed one. Extreme operands (all ones, most negative value) are checked on their own to expose width overflow in the widened adder. Directed sequences cover three more cases: a start during a run, writes during a run, and a start that collides with a write. Each of these shows whether control or data from the later stimulus leaked into HI and LO.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef enum logic [2:0] {
    BOP_NONE = 3'd0,
    BOP_ADD1 = 3'd1,
    BOP_ADD2 = 3'd2,
    BOP_SUB1 = 3'd3,
    BOP_SUB2 = 3'd4
  } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic [2:0] triple_i,
  output booth_op_e  op_o
);
  always_comb begin
    unique case (triple_i)
      3'b001, 3'b010: op_o = BOP_ADD1;
      3'b011:         op_o = BOP_ADD2;
      3'b100:         op_o = BOP_SUB2;
      3'b101, 3'b110: op_o = BOP_SUB1;
      default:        op_o = BOP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int W = 34
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mcand_i,
  input  booth_op_e    op_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] opnd;
  logic         sub;

  always_comb begin
    unique case (op_i)
      BOP_ADD1, BOP_SUB1: opnd = mcand_i;
      BOP_ADD2, BOP_SUB2: opnd = {mcand_i[W-2:0], 1'b0};
      default:            opnd = '0;
    endcase
    sub   = (op_i == BOP_SUB1) || (op_i == BOP_SUB2);
    sum_o = sub ? (acc_i - opnd) : (acc_i + opnd);
  end
endmodule

// File: rtl/mul_step_ctrl.sv
module mul_step_ctrl #(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic launch_o,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);
  localparam int CW = (STEPS > 2) ? $clog2(STEPS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;

  always_comb begin
    launch_o = start_i && !busy_q;
    last_o   = busy_q && (cnt_q == CW'(STEPS - 1));
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    done_d   = last_o;
    if (launch_o) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      busy_d = !last_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R4: done never overlaps busy
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R4: busy falls only together with a done pulse
  a_r4_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R4: step counter stays within the run length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CW'(STEPS - 1)));
  // R5: a start while busy does not restart the count
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic            hi_we_i,
  input  logic            lo_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  localparam int W     = XLEN + 2;
  localparam int STEPS = XLEN / 2;

  logic [W-1:0]    mcand_q, mcand_d, hi_q, hi_d, sum;
  logic [XLEN-1:0] lo_q, lo_d;
  logic            prev_q, prev_d, fix_q, fix_d;
  logic            launch, busy, last;
  logic            mcand_en, hi_en, lo_en;
  booth_op_e       step_op;

  mul_step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .launch_o(launch), .busy_o(busy), .last_o(last), .done_o(done_o)
  );

  booth_recoder u_rec (
    .triple_i({lo_q[1:0], prev_q}),
    .op_o(step_op)
  );

  booth_addsub #(.W(W)) u_add (
    .acc_i(hi_q), .mcand_i(mcand_q), .op_i(step_op), .sum_o(sum)
  );

  always_comb begin
    mcand_en = launch;
    hi_en    = launch || busy || hi_we_i;
    lo_en    = launch || busy || lo_we_i;
    mcand_d  = signed_i ? {{2{op_a_i[XLEN-1]}}, op_a_i} : {2'b00, op_a_i};
    fix_d    = !signed_i && op_b_i[XLEN-1];
    hi_d     = {2'b00, wdata_i};
    lo_d     = wdata_i;
    prev_d   = prev_q;
    if (launch) begin
      hi_d   = '0;
      lo_d   = op_b_i;
      prev_d = 1'b0;
    end else if (busy) begin
      hi_d   = {{2{sum[W-1]}}, sum[W-1:2]} + ((last && fix_q) ? mcand_q : '0);
      lo_d   = {sum[1:0], lo_q[XLEN-1:2]};
      prev_d = lo_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      fix_q   <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      prev_q  <= 1'b0;
    end else begin
      if (mcand_en) begin
        mcand_q <= mcand_d;
        fix_q   <= fix_d;
      end
      if (hi_en) hi_q <= hi_d;
      if (lo_en) begin
        lo_q   <= lo_d;
        prev_q <= prev_d;
      end
    end
  end

  assign busy_o = busy;
  assign hi_o   = hi_q[XLEN-1:0];
  assign lo_o   = lo_q;

  // R5: multiplicand held for the whole run
  a_r5_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand_q));
  // R9: a zero digit leaves the accumulator unchanged through the adder
  a_r9_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_op == BOP_NONE) |-> (sum == hi_q));
  // R6: idle LO write lands on the read port
  a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i && lo_we_i) |=> (lo_o == $past(wdata_i)));
  // R8: start beats a same-cycle HI write
  a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (busy && hi_o == '0));
endmodule

// File: tb/booth_mul_bench.sv
module booth_mul_bench;
  localparam int X     = 6;
  localparam int STEPS = X / 2;

  logic         clk, rst_n, start, sgn, hi_we, lo_we, busy, done;
  logic [X-1:0] a, b, wdata, hi, lo;
  int           n_chk, n_fail;

  booth_mul #(.XLEN(X)) u_booth_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
    .op_a_i(a), .op_b_i(b), .hi_we_i(hi_we), .lo_we_i(lo_we),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2*X-1:0] model(input logic [X-1:0] ma, mb, input logic ms);
    int ia, ib, p;
    ia = int'(ma);
    ib = int'(mb);
    if (ms && ma[X-1]) ia = ia - (1 << X);
    if (ms && mb[X-1]) ib = ib - (1 << X);
    p = ia * ib;
    return p[2*X-1:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a start at the current negedge; return at the negedge where done is expected
  task automatic launch(input logic [X-1:0] ta, tb, input logic ts);
    a = ta; b = tb; sgn = ts; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (STEPS) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; sgn = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    a = '0; b = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 hi", hi, 0);
    chk("R1 lo", lo, 0);

    // R4 timing of busy and done
    a = 6'd9; b = 6'd13; sgn = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R4 busy after start", busy, 1);
    chk("R4 no early done", done, 0);
    repeat (STEPS - 1) @(negedge clk);
    chk("R4 busy through last step", busy, 1);
    @(negedge clk);
    chk("R4 busy low at end", busy, 0);
    chk("R4 done pulse", done, 1);
    chk("R2 product 9*13", {hi, lo}, 117);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);

    // R5 start while busy ignored
    a = 6'd5; b = 6'd7; sgn = 1'b0; start = 1'b1;
    @(negedge clk);
    a = 6'd63; b = 6'd63; sgn = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (STEPS - 1) @(negedge clk);
    chk("R5 done of first op", done, 1);
    chk("R5 first product kept", {hi, lo}, 35);
    @(negedge clk);
    chk("R5 no second run busy", busy, 0);
    chk("R5 no second done", done, 0);

    // R6 idle direct writes
    wdata = 6'h2A; hi_we = 1'b1;
    @(negedge clk); hi_we = 1'b0;
    chk("R6 hi loaded", hi, 6'h2A);
    chk("R6 lo untouched", lo, 35);
    wdata = 6'h15; lo_we = 1'b1;
    @(negedge clk); lo_we = 1'b0;
    chk("R6 lo loaded", lo, 6'h15);
    chk("R6 hi untouched", hi, 6'h2A);

    // R7 writes during busy ignored
    a = 6'd11; b = 6'd22; sgn = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    hi_we = 1'b1; lo_we = 1'b1; wdata = 6'h3F;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b0;
    repeat (STEPS - 1) @(negedge clk);
    chk("R7 product unaffected", {hi, lo}, 242);

    // R8 start beats same-cycle write
    a = 6'd3; b = 6'd21; sgn = 1'b1; start = 1'b1; hi_we = 1'b1; lo_we = 1'b1; wdata = 6'h3F;
    @(negedge clk); start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    repeat (STEPS) @(negedge clk);
    chk("R8 start wins", {hi, lo}, model(6'd3, 6'd21, 1'b1));

    // R10 extension extremes, R9 mixed digit pattern
    launch(6'h3F, 6'h3F, 1'b0);
    chk("R10 unsigned all ones", {hi, lo}, model(6'h3F, 6'h3F, 1'b0));
    launch(6'h3F, 6'h3F, 1'b1);
    chk("R10 signed all ones", {hi, lo}, 1);
    launch(6'h20, 6'h20, 1'b1);
    chk("R10 signed most negative", {hi, lo}, model(6'h20, 6'h20, 1'b1));
    launch(6'h20, 6'h20, 1'b0);
    chk("R10 unsigned top bit", {hi, lo}, 1024);
    launch(6'd17, 6'b011010, 1'b0);
    chk("R9 digit pattern +2/-2/-1", {hi, lo}, 17 * 26);

    // exhaustive sweep: R2 unsigned, R3 signed (covers every R9 triple)
    for (int s = 0; s < 2; s++) begin
      for (int ia = 0; ia < (1 << X); ia++) begin
        for (int ib = 0; ib < (1 << X); ib++) begin
          launch(X'(ia), X'(ib), s[0]);
          if (s == 0) chk("R2 sweep", {done, hi, lo}, {1'b1, model(X'(ia), X'(ib), 1'b0)});
          else        chk("R3 sweep", {done, hi, lo}, {1'b1, model(X'(ia), X'(ib), 1'b1)});
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule